// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers 32 primary interrupt inputs and 32 secondary peripheral inputs into one CPU interrupt request. Three primary positions carry no input of their own. Each one is the OR of a group of pending secondary sources, so a peripheral group reaches the CPU through a single primary bit. Every input passes through a synchroniser. Each primary bit has a fixed type: level-following, edge-latched, or summary. A small set of edge-latched primary bits can also be raised by software.

Software uses a flat register port: one write strobe, an address, write data and a combinational read-back. Each level has a status view, a mask and a way to clear latched edges. The block registers a request line together with a 6-bit vector that names the winning source. Primary bits resolve lowest-number-first. When the winner is a summary bit, the vector moves into the upper half (32 to 63) and names the lowest pending secondary source.

Top module: `casc_irq_ctrl`

## Requirements
- R1: A primary bit is pending only when its status bit and its mask bit are both 1. A source with its mask bit at 0 never raises the request.
- R2: Register addresses: 0 reads the primary status; 1 is the primary mask (read/write); 2 is the primary edge latch (read/write); 3 is the write-only software-set register and reads 0; 4 reads the secondary status, and a write to it clears secondary latches; 5 is the secondary mask (read/write).
- R3: A level-type primary bit shows its input two clocks after the input changes and drops when the input drops.
- R4: Primary bits 16–19, 22–24 and 28–31 are edge-latched. A rising input edge sets the latch, and the latch holds after the input falls.
- R5: A write to address 2 clears every latch bit whose data bit is 0 and leaves every latch bit whose data bit is 1.
- R6: Primary status bit 4 is the OR of the pending secondary sources 16–31. Bit 5 is the OR of pending secondary sources 8–15, and bit 6 is the OR of pending secondary sources 0–7. A secondary source is pending when its status bit and its secondary mask bit are both 1.
- R7: Secondary sources 16, 22 and 28 are edge-latched, and a write to address 4 clears each of them whose data bit is 0. All other secondary sources follow their input.
- R8: The vector is the index of the lowest-numbered pending primary bit. When that bit is a summary bit, the vector is 32 plus the lowest pending secondary source, searched only in groups whose summary bit is unmasked at the primary level.
- R9: Reset clears the primary mask, the primary latches (including the software-set bits), the secondary latches and the secondary mask.
- R10: A write to address 3 sets primary latch bits 28–30 where its data bits are 1. Its other data bits are ignored.
- R11: When a new rising edge on a latched bit arrives in the same cycle as a write that clears that bit, the latch stays set.
- R12: The request, the valid flag and the vector are registered. They change one clock after the pending set changes.
- R13: When nothing is pending, the request and the valid flag are 0 and the vector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_src | input | 32 | Primary interrupt inputs (asynchronous) |
| sec_src | input | 32 | Secondary interrupt inputs (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Registered CPU interrupt request |
| irq_vec_valid | output | 1 | Vector valid flag |
| irq_vec | output | 6 | Winning source number (0–63) |

## Verification
The bench raises a new edge in the same cycle as a clearing write. A design where the clear wins loses that interrupt, and the latch read-back shows 0. It enables two secondary groups in different ways, so that a global lowest-bit search over the secondary sources names a source whose summary is masked (vector 41 instead of 52). It also checks a summary bit against lower- and higher-numbered primary bits, and checks that the software-set register ignores bits outside 28–30. It samples the request exactly one clock after a software set, which exposes a request that is combinational or delayed by two stages.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      SEL_PRI_STAT  = 3'd0,
      SEL_PRI_MASK  = 3'd1,
      SEL_PRI_LATCH = 3'd2,
      SEL_PRI_SET   = 3'd3,
      SEL_SEC_STAT  = 3'd4,
      SEL_SEC_MASK  = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/irq_sync_edge.sv
// Multi-stage synchroniser with one extra stage kept for rising-edge detection.
module irq_sync_edge #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [STAGES:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/irq_latch_bank.sv
// Sticky bits: a set input wins over a clear write in the same cycle.
module irq_latch_bank #(
   parameter int unsigned     W         = 32,
   parameter logic [W-1:0]    KEEP_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_we,
   input  logic [W-1:0] keep_i,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   assign held = clr_we ? (q & keep_i) : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (held | set_i) & KEEP_MASK;
   end
endmodule

// File: rtl/irq_lowest.sv
// Finds the index of the lowest set bit.
module irq_lowest #(
   parameter int unsigned W     = 32,
   parameter int unsigned IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/casc_irq_ctrl.sv
module casc_irq_ctrl #(
   parameter int unsigned     DATA_W         = 32,
   parameter int unsigned     SYNC_STAGES    = 2,
   parameter logic [DATA_W-1:0] PRI_EDGE_MASK  = 32'hF1CF_0000,
   parameter logic [DATA_W-1:0] PRI_SWSET_MASK = 32'h7000_0000,
   parameter logic [DATA_W-1:0] SEC_EDGE_MASK  = 32'h1041_0000,
   parameter int unsigned     SUM_HI_POS     = 4,
   parameter int unsigned     SUM_MID_POS    = 5,
   parameter int unsigned     SUM_LO_POS     = 6,
   parameter int unsigned     GRP_LO_TOP     = 7,
   parameter int unsigned     GRP_MID_TOP    = 15,
   localparam int unsigned    IDX_W          = $clog2(DATA_W),
   localparam int unsigned    VEC_W          = IDX_W + 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [DATA_W-1:0]               pri_src,
   input  logic [DATA_W-1:0]               sec_src,
   input  logic                            reg_we,
   input  logic [casc_irq_pkg::ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]               reg_wdata,
   output logic [DATA_W-1:0]               reg_rdata,
   output logic                            irq_req,
   output logic                            irq_vec_valid,
   output logic [VEC_W-1:0]                irq_vec
);
   import casc_irq_pkg::*;

   localparam logic [DATA_W-1:0] SUM_MASK = (DATA_W'(1) << SUM_HI_POS)
                                          | (DATA_W'(1) << SUM_MID_POS)
                                          | (DATA_W'(1) << SUM_LO_POS);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert ((SUM_MASK & PRI_EDGE_MASK) == '0) else $error("summary bits cannot be edge bits");
      assert ((PRI_SWSET_MASK & ~PRI_EDGE_MASK) == '0) else $error("software-set bits must be edge bits");
      assert (GRP_LO_TOP < GRP_MID_TOP && GRP_MID_TOP < DATA_W - 1) else $error("bad group bounds");
      assert (DATA_W == 2 ** IDX_W) else $error("DATA_W must be a power of two");
   end

   // ---------------- secondary level ----------------
   logic [DATA_W-1:0] sec_lvl, sec_rise, sec_latch_q, sec_stat, sec_pend;
   logic [DATA_W-1:0] sec_mask_q, grp_en, sec_elig;
   logic              sum_hi, sum_mid, sum_lo;

   irq_sync_edge #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sec_sync (
      .clk(clk), .rst_n(rst_n), .din(sec_src), .lvl(sec_lvl), .rise(sec_rise));

   irq_latch_bank #(.W(DATA_W), .KEEP_MASK(SEC_EDGE_MASK)) u_sec_latch (
      .clk(clk), .rst_n(rst_n), .set_i(sec_rise),
      .clr_we(reg_we && reg_addr == SEL_SEC_STAT),
      .keep_i(reg_wdata), .q(sec_latch_q));

   assign sec_stat = (sec_lvl & ~SEC_EDGE_MASK) | sec_latch_q;
   assign sec_pend = sec_stat & sec_mask_q;
   assign sum_lo   = |sec_pend[GRP_LO_TOP:0];
   assign sum_mid  = |sec_pend[GRP_MID_TOP:GRP_LO_TOP+1];
   assign sum_hi   = |sec_pend[DATA_W-1:GRP_MID_TOP+1];

   // ---------------- primary level ----------------
   logic [DATA_W-1:0] pri_lvl, pri_rise, pri_latch_q, pri_stat, pri_pend;
   logic [DATA_W-1:0] pri_mask_q, sw_set, sum_vec;

   irq_sync_edge #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_pri_sync (
      .clk(clk), .rst_n(rst_n), .din(pri_src), .lvl(pri_lvl), .rise(pri_rise));

   assign sw_set = (reg_we && reg_addr == SEL_PRI_SET) ? (reg_wdata & PRI_SWSET_MASK) : '0;

   irq_latch_bank #(.W(DATA_W), .KEEP_MASK(PRI_EDGE_MASK)) u_pri_latch (
      .clk(clk), .rst_n(rst_n), .set_i(pri_rise | sw_set),
      .clr_we(reg_we && reg_addr == SEL_PRI_LATCH),
      .keep_i(reg_wdata), .q(pri_latch_q));

   // Summary bits and the group enables that steer the secondary search.
   for (genvar g = 0; g < DATA_W; g++) begin : g_grp
      if (g <= GRP_LO_TOP) begin : g_lo
         assign grp_en[g] = pri_mask_q[SUM_LO_POS];
      end else if (g <= GRP_MID_TOP) begin : g_mid
         assign grp_en[g] = pri_mask_q[SUM_MID_POS];
      end else begin : g_hi
         assign grp_en[g] = pri_mask_q[SUM_HI_POS];
      end

      if (g == SUM_HI_POS) begin : g_shi
         assign sum_vec[g] = sum_hi;
      end else if (g == SUM_MID_POS) begin : g_smid
         assign sum_vec[g] = sum_mid;
      end else if (g == SUM_LO_POS) begin : g_slo
         assign sum_vec[g] = sum_lo;
      end else begin : g_snone
         assign sum_vec[g] = 1'b0;
      end
   end

   assign pri_stat = (pri_lvl & ~PRI_EDGE_MASK & ~SUM_MASK) | pri_latch_q | sum_vec;
   assign pri_pend = pri_stat & pri_mask_q;
   assign sec_elig = sec_pend & grp_en;

   // ---------------- resolution ----------------
   logic             pri_any, sec_any;
   logic [IDX_W-1:0] pri_idx, sec_idx;
   logic [VEC_W-1:0] vec_n;

   irq_lowest #(.W(DATA_W), .IDX_W(IDX_W)) u_pri_enc (.vec(pri_pend), .any(pri_any), .idx(pri_idx));
   irq_lowest #(.W(DATA_W), .IDX_W(IDX_W)) u_sec_enc (.vec(sec_elig), .any(sec_any), .idx(sec_idx));

   always_comb begin
      if (SUM_MASK[pri_idx] && sec_any) vec_n = {1'b1, sec_idx};
      else                              vec_n = {1'b0, pri_idx};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req       <= 1'b0;
         irq_vec_valid <= 1'b0;
         irq_vec       <= '0;
      end else begin
         irq_req       <= pri_any;
         irq_vec_valid <= pri_any;
         irq_vec       <= pri_any ? vec_n : '0;
      end
   end

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_mask_q <= '0;
         sec_mask_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == SEL_PRI_MASK) pri_mask_q <= reg_wdata;
         if (reg_addr == SEL_SEC_MASK) sec_mask_q <= reg_wdata;
      end
   end

   always_comb begin
      case (reg_addr)
         SEL_PRI_STAT:  reg_rdata = pri_stat;
         SEL_PRI_MASK:  reg_rdata = pri_mask_q;
         SEL_PRI_LATCH: reg_rdata = pri_latch_q;
         SEL_SEC_STAT:  reg_rdata = sec_stat;
         SEL_SEC_MASK:  reg_rdata = sec_mask_q;
         default:       reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/casc_irq_chk.sv
module casc_irq_chk #(
   parameter int unsigned        DATA_W   = 32,
   parameter int unsigned        VEC_W    = 6,
   parameter logic [DATA_W-1:0]  SUM_MASK = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] pri_pend,
   input logic [DATA_W-1:0] pri_latch_q,
   input logic [DATA_W-1:0] pri_mask_q,
   input logic [DATA_W-1:0] sec_mask_q,
   input logic              irq_req,
   input logic              irq_vec_valid,
   input logic [VEC_W-1:0]  irq_vec
);
   p_req_track_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_req == $past(|pri_pend)))
      else $error("request does not follow pending set one clock later");

   p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (!irq_vec_valid && irq_vec == '0))
      else $error("vector or valid active without request");

   p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == 3'd2) |=> ((pri_latch_q & $past(pri_latch_q)) == $past(pri_latch_q)))
      else $error("latched edge lost without a clear write");

   p_reset_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (pri_mask_q == '0 && pri_latch_q == '0 && sec_mask_q == '0))
      else $error("state not cleared by reset");

   p_sum_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_vec_valid && irq_vec >= VEC_W'(DATA_W)) |-> $past(|(pri_pend & SUM_MASK)))
      else $error("upper vector without a pending summary bit");
endmodule

bind casc_irq_ctrl casc_irq_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W), .SUM_MASK(SUM_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .pri_pend(pri_pend), .pri_latch_q(pri_latch_q), .pri_mask_q(pri_mask_q),
   .sec_mask_q(sec_mask_q), .irq_req(irq_req), .irq_vec_valid(irq_vec_valid),
   .irq_vec(irq_vec));

// File: tb/sim_casc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_casc_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pri_src = '0;
   logic [31:0] sec_src = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_req, irq_vec_valid;
   logic [5:0]  irq_vec;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      bit         req;
      logic [5:0] vec;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   casc_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pri_src(pri_src), .sec_src(sec_src),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec_valid(irq_vec_valid),
      .irq_vec(irq_vec));

   // Monitor: pops one expected item per falling edge and compares outputs.
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (irq_req !== e.req || irq_vec_valid !== e.req || irq_vec !== e.vec) begin
               errors++;
               $display("FAIL %s: req=%0b valid=%0b vec=%0d expected req=%0b valid=%0b vec=%0d",
                        e.tag, irq_req, irq_vec_valid, irq_vec, e.req, e.req, e.vec);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         errors++;
         $display("FAIL %s: addr %0d read 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
      end
   endtask

   task automatic expect_out(input bit req, input logic [5:0] vec, input string tag);
      exp_t e;
      e.req = req; e.vec = vec; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk); #1;
   endtask

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R9 / R13 reset state
      expect_out(0, 0, "R9 reset outputs");
      rd(3'd1, 32'h0, "R9 primary mask after reset");
      rd(3'd2, 32'h0, "R9 latch after reset");

      // R1 / R3 level source
      wr(3'd1, 32'h1 << 3);
      rd(3'd1, 32'h1 << 3, "R2 primary mask read-back");
      pri_src[3] = 1'b1;
      tick(5);
      expect_out(1, 6'd3, "R3 level source raises vector 3");
      wr(3'd1, 32'h0);
      tick(3);
      expect_out(0, 0, "R1 masked source not pending");
      wr(3'd1, 32'h1 << 3);
      tick(3);
      expect_out(1, 6'd3, "R1 unmasked again");
      pri_src[3] = 1'b0;
      tick(5);
      expect_out(0, 0, "R3 level drop clears request");

      // R4 edge latch
      wr(3'd1, 32'h1 << 17);
      pri_src[17] = 1'b1; tick(4);
      pri_src[17] = 1'b0; tick(5);
      expect_out(1, 6'd17, "R4 edge held after input falls");
      rd(3'd2, 32'h1 << 17, "R4 latch read");

      // R8 lowest wins
      pri_src[20] = 1'b1;
      wr(3'd1, (32'h1 << 17) | (32'h1 << 20));
      tick(5);
      expect_out(1, 6'd17, "R8 lowest of 17 and 20");

      // R5 acknowledge by write
      wr(3'd2, ~(32'h1 << 17));
      tick(3);
      expect_out(1, 6'd20, "R5 clear leaves level 20");
      rd(3'd2, 32'h0, "R5 latch cleared");
      pri_src[20] = 1'b0;
      wr(3'd1, 32'h0);
      tick(5);

      // R6 summary bit 5 for secondary 9
      wr(3'd5, 32'h1 << 9);
      sec_src[9] = 1'b1;
      wr(3'd1, 32'h1 << 5);
      tick(5);
      expect_out(1, 6'd41, "R6 summary vector 32+9");
      rd(3'd0, 32'h1 << 5, "R6 primary status shows summary bit 5");
      wr(3'd5, 32'h0);
      tick(3);
      expect_out(0, 0, "R6 secondary mask removes summary");
      rd(3'd0, 32'h0, "R6 status without secondary mask");

      // R8 summary versus other primary bits
      wr(3'd5, 32'h1 << 9);
      pri_src[3] = 1'b1;
      wr(3'd1, (32'h1 << 3) | (32'h1 << 5));
      tick(5);
      expect_out(1, 6'd3, "R8 primary 3 beats summary 5");
      pri_src[7] = 1'b1;
      wr(3'd1, (32'h1 << 5) | (32'h1 << 7));
      tick(5);
      expect_out(1, 6'd41, "R8 summary 5 beats primary 7");

      // R8 group enable steers secondary search
      sec_src[20] = 1'b1;
      wr(3'd5, (32'h1 << 9) | (32'h1 << 20));
      wr(3'd1, 32'h1 << 4);
      tick(5);
      expect_out(1, 6'd52, "R8 only enabled group searched");
      pri_src = '0; sec_src = '0;
      wr(3'd5, 32'h0);
      wr(3'd1, 32'h0);
      tick(5);

      // R7 secondary edge 22
      wr(3'd5, 32'h1 << 22);
      wr(3'd1, 32'h1 << 4);
      sec_src[22] = 1'b1; tick(4);
      sec_src[22] = 1'b0; tick(5);
      expect_out(1, 6'd54, "R7 secondary edge held");
      rd(3'd4, 32'h1 << 22, "R7 secondary status latch");
      wr(3'd4, ~(32'h1 << 22));
      tick(3);
      expect_out(0, 0, "R7 secondary latch cleared");
      rd(3'd4, 32'h0, "R7 secondary status after clear");
      wr(3'd5, 32'h0);
      wr(3'd1, 32'h0);

      // R10 / R12 software set and request timing
      wr(3'd1, 32'h1 << 29);
      tick(2);
      wr(3'd3, (32'h1 << 29) | (32'h1 << 5) | (32'h1 << 17));
      expect_out(0, 0, "R12 request not yet up in set cycle");
      expect_out(1, 6'd29, "R12 request one clock after set");
      rd(3'd2, 32'h1 << 29, "R10 only bit 29 set");
      rd(3'd3, 32'h0, "R2 set register reads zero");
      wr(3'd2, 32'h0);
      tick(3);
      expect_out(0, 0, "R13 idle after clear");

      // R11 new edge beats clear write
      wr(3'd1, 32'h1 << 18);
      @(posedge clk); #1;
      pri_src[18] = 1'b1;
      @(posedge clk); #1;
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h0;
      @(posedge clk); #1;
      reg_we = 1'b0;
      rd(3'd2, 32'h1 << 18, "R11 edge wins over clear");
      pri_src[18] = 1'b0;
      tick(3);
      expect_out(1, 6'd18, "R11 vector 18 after race");

      // R9 reset mid-run
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd5, 32'h0000_00FF);
      wr(3'd3, 32'h1 << 28);
      tick(2);
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(2);
      expect_out(0, 0, "R9 outputs after reset");
      rd(3'd1, 32'h0, "R9 primary mask cleared");
      rd(3'd2, 32'h0, "R9 latches cleared");
      rd(3'd5, 32'h0, "R9 secondary mask cleared");

      tick(2);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule